// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a four-wire, SPI-compatible configuration link. It fronts a bank of 8-bit configuration registers. An external master drives a program clock, a serial data input and an active-low select, and the block answers on a serial data output that has its own output enable. Every transaction is one 16-bit frame. The frame starts with a 7-bit register address, most significant bit first. A direction flag follows (1 = write, 0 = read), and the frame ends with 8 data bits, D7 first. The whole register bank is also driven out in parallel, so the rest of the chip can use the settings directly.

The block runs on the chip's system clock. The three master lines are oversampled through synchronizers, and program-clock edges are found from the synchronized copies. A write frame stores its byte only when the sixteenth bit is taken. A frame that stops early leaves every register as it was. A read frame puts the addressed byte on the data output: each bit changes after a falling program-clock edge, so the master can sample it on the following rising edge. Addresses at or above the number of implemented registers are not backed by storage.

Top module: `cfg_serial_port`

## Requirements
- R1: A complete write frame (bits in order: A6..A0, flag = 1, D7..D0, each sampled on a rising program-clock edge while select is low) stores D7..D0 into register A6..A0. Register n appears on `cfg_regs_o[8n+7:8n]`.
- R2: A complete read frame (flag = 0) returns the addressed register on `cfg_sdo`. D7 is valid at the 9th rising program-clock edge and D0 at the 16th. The frame modifies no register.
- R3: A write takes effect only once the 16th bit has been sampled. After 15 bits, the addressed register still holds its old value.
- R4: If select is raised before the 16th bit, no register is modified. The next frame starts again from its first bit.
- R5: `cfg_sdo_oe` is high while select is low. It is low, and `cfg_sdo` is 0, within four system clocks of select going high.
- R6: A write to an address at or above NUM_REGS changes no register. A read of such an address returns 0x00.
- R7: Registers can be written in any order. A write changes only the addressed register, and values persist across later read frames and idle time.
- R8: While `rst_n` is low, all registers read as zero and `cfg_sdo_oe` and `cfg_sdo` are low.
- R9: If the 16th rising program-clock edge and the release of select reach the block in the same synchronized cycle, select wins and the frame is aborted with no write.
- R10: Program-clock pulses after the 16th bit of a frame are ignored. The stored value is the one from bits 9..16, and it is stored once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sck | input | 1 | Program clock from the master |
| cfg_sdi | input | 1 | Serial data from the master |
| cfg_csn | input | 1 | Active-low frame select |
| cfg_sdo | output | 1 | Serial readback data |
| cfg_sdo_oe | output | 1 | Output enable for cfg_sdo |
| cfg_regs_o | output | NUM_REGS*8 | All registers, register n at bits 8n+7..8n |

## Verification
The write commit on the last rising program clock and the frame abort on select release can land in the same synchronized cycle. The bench provokes this by raising the program clock and the select line at the same system-clock edge on the sixteenth bit of a write. It then checks at the parallel outputs that the target register did not change, and that an ordinary resend of the same frame lands. A monitor decodes frames from the pins on its own, so readback immediately after such a race, and after a commit, is judged against values the driver queued.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + 1 + DATA_W;
  localparam int SHIFT_W = FRAME_W - 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DATA_W-1:0]  data_t;
  typedef logic [SHIFT_W-1:0] shift_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // counter value helper
  function automatic cnt_t cnt_of(input int v);
    return cnt_t'(v);
  endfunction

  // address held in the shifter once the header's address part is in
  function automatic addr_t hdr_addr_of(input shift_t s);
    return s[ADDR_W-1:0];
  endfunction

  // with 15 bits shifted: address occupies the top seven positions
  function automatic addr_t frame_addr_of(input shift_t s);
    return s[SHIFT_W-1 -: ADDR_W];
  endfunction

  // with 15 bits shifted: direction flag sits just above the 7 data bits
  function automatic logic frame_rw_of(input shift_t s);
    return s[DATA_W-1];
  endfunction

  // with 15 bits shifted plus the incoming last bit: full data byte
  function automatic data_t frame_data_of(input shift_t s, input logic last_bit);
    return {s[DATA_W-2:0], last_bit};
  endfunction

  // true when the address is backed by a register
  function automatic logic addr_ok(input addr_t a, input int nregs);
    return int'(a) < nregs;
  endfunction

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
  parameter int               W       = 1,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cfgport_frame.sv
module cfgport_frame
  import cfgport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_s,
  input  logic  sdi_s,
  input  logic  csn_s,
  output logic  sel,
  output logic  sck_fall,
  output cnt_t  bit_cnt,
  output logic  hdr_rw,
  output logic  hdr_take,
  output addr_t hdr_addr,
  output logic  rd_launch,
  output logic  wr_en,
  output addr_t wr_addr,
  output data_t wr_data
);

  localparam cnt_t CNT_HDR  = cnt_of(ADDR_W);
  localparam cnt_t CNT_LAST = cnt_of(FRAME_W - 1);
  localparam cnt_t CNT_FULL = cnt_of(FRAME_W);

  logic   sck_d;
  shift_t shreg;
  logic   sck_rise;
  logic   take;
  logic   last_take;

  assign sel      = ~csn_s;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  // select has priority: an edge seen while deselected is dropped
  assign take      = sck_rise & sel & (bit_cnt != CNT_FULL);
  assign hdr_take  = take & (bit_cnt == CNT_HDR);
  assign last_take = take & (bit_cnt == CNT_LAST);

  assign hdr_addr  = hdr_addr_of(shreg);
  assign rd_launch = hdr_take & ~sdi_s;

  assign wr_addr = frame_addr_of(shreg);
  assign wr_data = frame_data_of(shreg, sdi_s);
  assign wr_en   = last_take & frame_rw_of(shreg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      hdr_rw  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      if (!sel) begin
        bit_cnt <= '0;
        shreg   <= '0;
        hdr_rw  <= 1'b1;
      end else if (take) begin
        shreg   <= {shreg[SHIFT_W-2:0], sdi_s};
        bit_cnt <= bit_cnt + cnt_of(1);
        if (hdr_take) hdr_rw <= sdi_s;
      end
    end
  end

endmodule

// File: rtl/cfgport_regbank.sv
module cfgport_regbank
  import cfgport_pkg::*;
#(
  parameter int NUM_REGS = 33
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  addr_t                      wr_addr,
  input  data_t                      wr_data,
  input  addr_t                      rd_addr,
  output data_t                      rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  data_t mem_q [NUM_REGS];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  mem_q[g] <= '0;
        else if (wr_en && wr_addr == ADDR_W'(g))     mem_q[g] <= wr_data;
      end
      assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (addr_ok(rd_addr, NUM_REGS)) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (rd_addr == ADDR_W'(i)) rd_data = mem_q[i];
      end
    end
  end

endmodule

// File: rtl/cfgport_readout.sv
module cfgport_readout
  import cfgport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sel,
  input  logic  sck_fall,
  input  cnt_t  bit_cnt,
  input  logic  launch,
  input  data_t launch_data,
  output logic  sdo,
  output logic  sdo_oe
);

  localparam cnt_t CNT_FIRST = cnt_of(ADDR_W + 1);
  localparam cnt_t CNT_FULL  = cnt_of(FRAME_W);

  data_t rd_sr;
  logic  armed;
  logic  in_data;

  assign in_data = (bit_cnt >= CNT_FIRST) && (bit_cnt < CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sr  <= '0;
      armed  <= 1'b0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (!sel) begin
      rd_sr  <= '0;
      armed  <= 1'b0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sdo_oe <= 1'b1;
      if (launch) begin
        rd_sr <= launch_data;
        armed <= 1'b1;
      end else if (armed && sck_fall && in_data) begin
        sdo   <= rd_sr[DATA_W-1];
        rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgport_pkg::*;
#(
  parameter int NUM_REGS    = 33,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_sck,
  input  logic                       cfg_sdi,
  input  logic                       cfg_csn,
  output logic                       cfg_sdo,
  output logic                       cfg_sdo_oe,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs_o
);

  logic  sck_s, sdi_s, csn_s;
  logic  sel, sck_fall, hdr_rw, hdr_take, rd_launch, wr_en;
  cnt_t  bit_cnt;
  addr_t hdr_addr, wr_addr;
  data_t wr_data, rd_data;

  cfgport_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b001)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cfg_sck, cfg_sdi, cfg_csn}),
    .q     ({sck_s, sdi_s, csn_s})
  );

  cfgport_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (sck_s),
    .sdi_s     (sdi_s),
    .csn_s     (csn_s),
    .sel       (sel),
    .sck_fall  (sck_fall),
    .bit_cnt   (bit_cnt),
    .hdr_rw    (hdr_rw),
    .hdr_take  (hdr_take),
    .hdr_addr  (hdr_addr),
    .rd_launch (rd_launch),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  cfgport_regbank #(
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (hdr_addr),
    .rd_data (rd_data),
    .regs_o  (cfg_regs_o)
  );

  cfgport_readout u_rdout (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .sck_fall    (sck_fall),
    .bit_cnt     (bit_cnt),
    .launch      (rd_launch),
    .launch_data (rd_data),
    .sdo         (cfg_sdo),
    .sdo_oe      (cfg_sdo_oe)
  );

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
  import cfgport_pkg::*;
#(
  parameter int NUM_REGS = 33
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       csn_s,
  input cnt_t                       bit_cnt,
  input logic                       hdr_rw,
  input logic                       wr_en,
  input addr_t                      wr_addr,
  input logic [NUM_REGS*DATA_W-1:0] regs,
  input logic                       sdo,
  input logic                       sdo_oe
);

  localparam cnt_t CNT_FIRST = cnt_of(ADDR_W + 1);
  localparam cnt_t CNT_FULL  = cnt_of(FRAME_W);

  // R3: register contents move only on the cycle after a commit
  a_r3_change_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(wr_en));

  // R4, R9: no commit while deselected
  a_r4_commit_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !csn_s);

  // R2: a read frame never commits
  a_r2_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt >= CNT_FIRST && !hdr_rw) |-> !wr_en);

  // R5: deselect turns the output off
  a_r5_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdo_oe);

  // R5: output held low while not enabled
  a_r5_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R6: unbacked address writes leave the bank untouched
  a_r6_oor_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ok(wr_addr, NUM_REGS)) |=> $stable(regs));

  // R10: after the commit the counter parks at a full frame
  a_r10_count_parks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bit_cnt == CNT_FULL));

endmodule

bind cfg_serial_port cfgport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csn_s   (csn_s),
  .bit_cnt (bit_cnt),
  .hdr_rw  (hdr_rw),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .regs    (cfg_regs_o),
  .sdo     (cfg_sdo),
  .sdo_oe  (cfg_sdo_oe)
);

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;

  localparam int NREG = 33;
  localparam int H    = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, csn = 1'b1;
  logic sdo, oe;
  logic [NREG*8-1:0] regs;

  always #10 clk = ~clk;

  cfg_serial_port #(.NUM_REGS(NREG), .SYNC_STAGES(2)) u_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .cfg_sck(sck), .cfg_sdi(sdi), .cfg_csn(csn),
    .cfg_sdo(sdo), .cfg_sdo_oe(oe), .cfg_regs_o(regs)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] rg(input int a);
    return regs[a*8 +: 8];
  endfunction

  task automatic sel_on();
    @(negedge clk); csn = 1'b0;
    wclk(H);
  endtask

  task automatic send_bit(input logic b, input bit race);
    @(negedge clk); sdi = b;
    wclk(H); sck = 1'b1;
    if (race) csn = 1'b1;
    wclk(H); sck = 1'b0;
  endtask

  task automatic sel_off();
    wclk(H); csn = 1'b1;
    wclk(3*H);
  endtask

  task automatic frame(input logic [6:0] a, input logic rw, input logic [7:0] d,
                       input int nbits, input bit race);
    logic [15:0] word;
    word = {a, rw, d};
    sel_on();
    for (int i = 0; i < nbits; i++)
      send_bit((i < 16) ? word[15-i] : 1'b1, race && (i == nbits-1));
    if (race) wclk(3*H);
    else      sel_off();
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    frame(a, 1'b1, d, 16, 1'b0);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    frame(a, 1'b0, 8'h00, 16, 1'b0);
  endtask

  // monitor: decodes frames from the pins and scores readback
  initial begin
    int cnt;
    logic [15:0] fr;
    logic [7:0]  rdv;
    logic [7:0]  e;
    string       t;
    forever begin
      @(negedge csn);
      cnt = 0; fr = '0; rdv = '0;
      while (1) begin
        @(posedge sck or posedge csn);
        if (csn) break;
        if (cnt < 16) begin
          fr[15-cnt] = sdi;
          if (cnt >= 8) rdv[15-cnt] = sdo;
        end
        cnt++;
      end
      if (cnt == 16 && fr[8] == 1'b0) begin
        if (exp_q.size() == 0) begin
          chk("R2 unexpected read frame", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {24'd0, rdv}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NREG*8-1:0] snap;
    logic [15:0] word;

    // R8 reset state
    wclk(5);
    chk("R8 regs zero in reset", {31'd0, regs == '0}, 32'd1);
    chk("R8 oe low in reset", {31'd0, oe}, 32'd0);
    chk("R8 sdo low in reset", {31'd0, sdo}, 32'd0);
    rst_n = 1'b1;
    wclk(5);

    // R1 / R7 writes in scattered order
    do_write(7'd5, 8'hA5);
    chk("R1 reg5 written", {24'd0, rg(5)}, 32'hA5);
    do_write(7'd32, 8'h81);
    do_write(7'd0, 8'h3C);
    do_write(7'd17, 8'h6E);
    chk("R7 reg32", {24'd0, rg(32)}, 32'h81);
    chk("R7 reg0", {24'd0, rg(0)}, 32'h3C);
    chk("R7 reg17", {24'd0, rg(17)}, 32'h6E);
    chk("R7 reg5 kept", {24'd0, rg(5)}, 32'hA5);
    chk("R7 reg1 untouched", {24'd0, rg(1)}, 32'h00);

    // R2 readback, bank unchanged by reads
    snap = regs;
    do_read(7'd5, 8'hA5, "R2 read reg5");
    do_read(7'd32, 8'h81, "R2 read reg32");
    do_read(7'd0, 8'h3C, "R2 read reg0");
    chk("R2 reads modify nothing", {31'd0, regs == snap}, 32'd1);

    // R3 commit only on the 16th bit
    word = {7'd9, 1'b1, 8'h5A};
    sel_on();
    for (int i = 0; i < 15; i++) send_bit(word[15-i], 1'b0);
    wclk(3*H);
    chk("R3 no write after 15 bits", {24'd0, rg(9)}, 32'h00);
    send_bit(word[0], 1'b0);
    chk("R3 write after 16th bit", {24'd0, rg(9)}, 32'h5A);
    sel_off();

    // R4 abort, then a clean frame
    frame(7'd9, 1'b1, 8'hFF, 12, 1'b0);
    chk("R4 aborted frame no write", {24'd0, rg(9)}, 32'h5A);
    do_write(7'd10, 8'h77);
    chk("R4 frame after abort", {24'd0, rg(10)}, 32'h77);

    // R5 output enable follows select
    sel_on();
    chk("R5 oe high when selected", {31'd0, oe}, 32'd1);
    sel_off();
    chk("R5 oe low when deselected", {31'd0, oe}, 32'd0);
    chk("R5 sdo low when deselected", {31'd0, sdo}, 32'd0);

    // R6 unbacked addresses
    snap = regs;
    do_write(7'd100, 8'hEE);
    chk("R6 oor write ignored", {31'd0, regs == snap}, 32'd1);
    do_write(7'd33, 8'hEE);
    chk("R6 write at NUM_REGS ignored", {31'd0, regs == snap}, 32'd1);
    do_read(7'd100, 8'h00, "R6 oor read zero");
    do_read(7'd33, 8'h00, "R6 read at NUM_REGS zero");

    // R9 last edge and select release together
    frame(7'd11, 1'b1, 8'h99, 16, 1'b1);
    chk("R9 race aborts write", {24'd0, rg(11)}, 32'h00);
    do_read(7'd11, 8'h00, "R9 readback after race");
    do_write(7'd11, 8'h99);
    chk("R9 resend lands", {24'd0, rg(11)}, 32'h99);

    // R10 extra clocks ignored
    frame(7'd12, 1'b1, 8'hC3, 20, 1'b0);
    chk("R10 extra clocks ignored", {24'd0, rg(12)}, 32'hC3);
    do_read(7'd12, 8'hC3, "R10 read after long frame");
    do_read(7'd17, 8'h6E, "R7 value persists");

    wclk(20);
    chk("R2 all reads scored", exp_q.size(), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule